// File: doc/BRIEF.md
# Buffer Pool Threshold Event Generator

This block turns three buffer-pool occupancy comparisons into a stream of resource events for a downstream receive-queue manager. The three comparisons are a per-descriptor-type count against its threshold, a total count against its threshold, and a per-pool count against its threshold. An event is raised when a count first reaches its threshold from below. Each event is presented on a valid/ready handshake, and a kind code identifies the source.

A global switch gates the whole event path. Each source also has its own arm bit in a small enable register, which software writes and reads back. In limit mode, the first accepted event of a source clears that source's arm bit. Later crossings of that source are then discarded until software sets the bit again. When several sources fire together, the block queues them and presents them one at a time in a fixed order. Counting the occupancy itself is done elsewhere.

Top module: `res_evt_gen`

## Requirements
- R1: After a synchronous active-low reset, `evt_valid` is 0 and `en_rd` reads 3'b000.
- R2: A source produces one event when its count goes from below its threshold to greater than or equal to it. A count that stays at or above the threshold produces no further events. It must drop below the threshold and reach it again to produce another event.
- R3: While `cfg_evt_on` is 0, crossings are discarded. Setting `cfg_evt_on` afterwards, while a count is still above its threshold, produces no event.
- R4: A crossing of a source whose arm bit is 0 is discarded. Arm bits are `en_rd[0]` for the type source, `en_rd[1]` for the total source and `en_rd[2]` for the pool source.
- R5: With `cfg_limit` set, an accepted crossing clears that source's arm bit on the same clock edge. With `cfg_limit` clear, the arm bits change only on software writes.
- R6: In limit mode, crossings of a disarmed source are lost and not queued. After software re-arms the source, its next crossing produces an event.
- R7: Sources that fire in the same cycle are presented one per handshake in the order type, total, pool. The `evt_kind` codes are 0 for type, 1 for total and 2 for pool; code 3 never appears with `evt_valid`.
- R8: While `evt_valid` is 1 and `evt_ready` is 0, `evt_valid` and `evt_kind` hold their values.
- R9: A software write (`en_wr`) in the same cycle as a limit-mode clear wins. The enable register takes `en_wdata` exactly. An arm bit only ever becomes 1 through a software write.
- R10: Suppose a crossing is present on the inputs in the cycle before clock edge k, and no earlier event is waiting. Then `evt_valid` is 0 after edge k and 1 after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_evt_on | input | 1 | Global event enable |
| cfg_limit | input | 1 | Limit mode: disarm a source after its first accepted event |
| occ_type | input | CNT_W | Per-descriptor-type occupancy count |
| occ_total | input | CNT_W | Total occupancy count |
| occ_pool | input | CNT_W | Per-pool occupancy count |
| thr_type | input | CNT_W | Threshold for the type count |
| thr_total | input | CNT_W | Threshold for the total count |
| thr_pool | input | CNT_W | Threshold for the pool count |
| en_wr | input | 1 | Software write strobe for the enable register |
| en_wdata | input | 3 | Enable register write value (bit 0 type, bit 1 total, bit 2 pool) |
| en_rd | output | 3 | Enable register readback |
| evt_valid | output | 1 | Event present |
| evt_kind | output | 2 | Event source code (0 type, 1 total, 2 pool) |
| evt_ready | input | 1 | Downstream accepts the presented event |

## Verification
The bench sweeps every combination of global enable, limit mode, arm mask and set of sources crossing together. It checks the number and order of the events and the arm bits left behind. A design that gated on the wrong enable, or swapped the priority, would produce the wrong event list. A design that forgot to disarm would leave the wrong readback. Directed cases cover three more faults:
- A level-triggered design would emit an event again on every cycle above the threshold, or when the global enable turns on late.
- A design that queued crossings seen while disarmed would produce an event after re-arming.
- A design where the hardware clear beat a same-cycle software write would read back a cleared bit.

A stalled handshake checks that the presented kind stays fixed and is not overtaken.

// File: rtl/res_evt_pkg.sv
// Package: shared constants and the event kind encoding for the
// threshold event generator. The source count is fixed at three; the kind
// code doubles as the fixed presentation priority (lower code first).
package res_evt_pkg;

    localparam int unsigned NSRC   = 3;
    localparam int unsigned KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        EVK_TYPE  = 2'd0,
        EVK_TOTAL = 2'd1,
        EVK_POOL  = 2'd2
    } evt_kind_e;

endpackage

// File: rtl/res_cross_det.sv
// Module: res_cross_det
// Detects, per source, the cycle in which an occupancy count first reaches
// its threshold (count >= threshold after being below it).
// Assumes counts and thresholds are unsigned and already synchronous to clk.
module res_cross_det #(
    parameter int unsigned NSRC  = 3,
    parameter int unsigned CNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0][CNT_W-1:0] occ,
    input  logic [NSRC-1:0][CNT_W-1:0] thr,
    output logic [NSRC-1:0]            rise
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic hit;
        logic hit_q;

        // Level comparison of this source against its threshold.
        always_comb begin
            hit = (occ[i] >= thr[i]);
        end

        // Remember last cycle's level so only the rising crossing counts.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_q <= 1'b0;
            end else begin
                hit_q <= hit;
            end
        end

        // Crossing pulse: at threshold now, below it last cycle.
        always_comb begin
            rise[i] = hit && !hit_q;
        end
    end

endmodule

// File: rtl/res_arm_ctrl.sv
// Module: res_arm_ctrl
// Holds the per-source arm (enable) bits and the pending-event flags.
// A crossing is accepted only if the global switch and the source's arm bit
// are set; otherwise it is discarded. In limit mode an accepted crossing
// disarms its source, unless software writes the register in that cycle.
// Assumes take is one-hot or zero and only names pending sources.
module res_arm_ctrl #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            glb_on,
    input  logic            limit_on,
    input  logic [NSRC-1:0] rise,
    input  logic            sw_wr,
    input  logic [NSRC-1:0] sw_data,
    input  logic [NSRC-1:0] take,
    output logic [NSRC-1:0] arm_q,
    output logic [NSRC-1:0] pend_q
);

    logic [NSRC-1:0] accept;
    logic [NSRC-1:0] arm_d;
    logic [NSRC-1:0] pend_d;

    // Qualify crossings with the global switch and the per-source arm bits.
    always_comb begin
        accept = rise & arm_q & {NSRC{glb_on}};
    end

    // Next arm value: software write wins, else limit mode disarms accepted sources.
    always_comb begin
        if (sw_wr) begin
            arm_d = sw_data;
        end else if (limit_on) begin
            arm_d = arm_q & ~accept;
        end else begin
            arm_d = arm_q;
        end
    end

    // Next pending value: drop the source handed to the output, add new accepts.
    always_comb begin
        pend_d = (pend_q & ~take) | accept;
    end

    // State update for arm bits and pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q  <= '0;
            pend_q <= '0;
        end else begin
            arm_q  <= arm_d;
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/res_evt_arb.sv
// Module: res_evt_arb
// Fixed-priority selector and output register. Picks the lowest-index
// pending source whenever the output slot is empty or being accepted, so a
// presented event never changes while the downstream stalls.
// Assumes the consumer follows valid/ready: transfer when both are high.
module res_evt_arb
    import res_evt_pkg::*;
#(
    parameter int unsigned NSRC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   pend,
    input  logic              ready,
    output logic [NSRC-1:0]   take,
    output logic              valid_q,
    output logic [KIND_W-1:0] kind_q
);

    logic              load;
    logic [KIND_W-1:0] sel;

    // Slot can be refilled when empty or when its event is being accepted.
    always_comb begin
        load = (|pend) && (!valid_q || ready);
    end

    // Lowest pending index wins; flag it as taken when loading.
    always_comb begin
        sel  = '0;
        take = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                sel = KIND_W'(i);
            end
        end
        if (load) begin
            take[sel] = 1'b1;
        end
    end

    // Output slot: load a new event, or empty after a transfer with nothing waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            kind_q  <= EVK_TYPE;
        end else if (load) begin
            valid_q <= 1'b1;
            kind_q  <= sel;
        end else if (ready) begin
            valid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/res_evt_gen.sv
// Module: res_evt_gen (top)
// Threshold event generator for a buffer pool. Three occupancy comparisons
// (type, total, pool) raise events on their rising crossing; events are
// gated globally and per source, optionally rate-limited to one per arm, and
// presented one at a time on a valid/ready handshake.
// Assumes occupancy counting and threshold programming happen outside.
module res_evt_gen
    import res_evt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_evt_on,
    input  logic              cfg_limit,
    input  logic [CNT_W-1:0]  occ_type,
    input  logic [CNT_W-1:0]  occ_total,
    input  logic [CNT_W-1:0]  occ_pool,
    input  logic [CNT_W-1:0]  thr_type,
    input  logic [CNT_W-1:0]  thr_total,
    input  logic [CNT_W-1:0]  thr_pool,
    input  logic              en_wr,
    input  logic [NSRC-1:0]   en_wdata,
    output logic [NSRC-1:0]   en_rd,
    output logic              evt_valid,
    output logic [KIND_W-1:0] evt_kind,
    input  logic              evt_ready
);

    logic [NSRC-1:0][CNT_W-1:0] occ_v;
    logic [NSRC-1:0][CNT_W-1:0] thr_v;
    logic [NSRC-1:0]            rise;
    logic [NSRC-1:0]            take;
    logic [NSRC-1:0]            pend;
    logic [NSRC-1:0]            arm;

    // Pack the per-source ports in priority order (type, total, pool).
    always_comb begin
        occ_v[EVK_TYPE]  = occ_type;
        occ_v[EVK_TOTAL] = occ_total;
        occ_v[EVK_POOL]  = occ_pool;
        thr_v[EVK_TYPE]  = thr_type;
        thr_v[EVK_TOTAL] = thr_total;
        thr_v[EVK_POOL]  = thr_pool;
    end

    res_cross_det #(
        .NSRC  (NSRC),
        .CNT_W (CNT_W)
    ) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .occ   (occ_v),
        .thr   (thr_v),
        .rise  (rise)
    );

    res_arm_ctrl #(
        .NSRC (NSRC)
    ) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .glb_on   (cfg_evt_on),
        .limit_on (cfg_limit),
        .rise     (rise),
        .sw_wr    (en_wr),
        .sw_data  (en_wdata),
        .take     (take),
        .arm_q    (arm),
        .pend_q   (pend)
    );

    res_evt_arb #(
        .NSRC (NSRC)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .ready   (evt_ready),
        .take    (take),
        .valid_q (evt_valid),
        .kind_q  (evt_kind)
    );

    // Enable register readback.
    always_comb begin
        en_rd = arm;
    end

endmodule

// File: rtl/res_evt_gen_chk.sv
// Module: res_evt_gen_chk
// Port-level properties of res_evt_gen, attached with bind below.
module res_evt_gen_chk
    import res_evt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_evt_on,
    input logic              cfg_limit,
    input logic              en_wr,
    input logic [NSRC-1:0]   en_wdata,
    input logic [NSRC-1:0]   en_rd,
    input logic              evt_valid,
    input logic [KIND_W-1:0] evt_kind,
    input logic              evt_ready
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!evt_valid && en_rd == '0));

    // R3
    glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(evt_valid) |-> $past(cfg_evt_on, 2));

    // R7
    kind_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_kind != 2'd3));

    // R8
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_kind)));

    // R9
    sw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en_wr) |-> (en_rd == $past(en_wdata)));

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        // R5
        disarm_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en_rd[i]) |-> ($past(cfg_limit) || $past(en_wr)));

        // R9
        arm_by_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_rd[i]) |-> $past(en_wr));
    end

endmodule

bind res_evt_gen res_evt_gen_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_evt_on (cfg_evt_on),
    .cfg_limit  (cfg_limit),
    .en_wr      (en_wr),
    .en_wdata   (en_wdata),
    .en_rd      (en_rd),
    .evt_valid  (evt_valid),
    .evt_kind   (evt_kind),
    .evt_ready  (evt_ready)
);

// File: tb/res_evt_gen_tb.sv
// Bench for res_evt_gen: full sweep of enable/limit/arm/crossing sets plus
// directed cases for edge triggering, stalls, re-arming and write priority.
module res_evt_gen_tb;

    localparam int CNT_W = 8;
    localparam logic [CNT_W-1:0] THR = 8'd5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_evt_on = 1'b0;
    logic             cfg_limit = 1'b0;
    logic [CNT_W-1:0] occ_type = '0;
    logic [CNT_W-1:0] occ_total = '0;
    logic [CNT_W-1:0] occ_pool = '0;
    logic [CNT_W-1:0] thr_type = THR;
    logic [CNT_W-1:0] thr_total = THR;
    logic [CNT_W-1:0] thr_pool = THR;
    logic             en_wr = 1'b0;
    logic [2:0]       en_wdata = '0;
    logic [2:0]       en_rd;
    logic             evt_valid;
    logic [1:0]       evt_kind;
    logic             evt_ready = 1'b1;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    res_evt_gen #(.CNT_W(CNT_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_evt_on (cfg_evt_on),
        .cfg_limit  (cfg_limit),
        .occ_type   (occ_type),
        .occ_total  (occ_total),
        .occ_pool   (occ_pool),
        .thr_type   (thr_type),
        .thr_total  (thr_total),
        .thr_pool   (thr_pool),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .en_rd      (en_rd),
        .evt_valid  (evt_valid),
        .evt_kind   (evt_kind),
        .evt_ready  (evt_ready)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_occ(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b,
                           input logic [CNT_W-1:0] c);
        occ_type = a; occ_total = b; occ_pool = c;
    endtask

    task automatic wr_en(input logic [2:0] v);
        en_wr = 1'b1; en_wdata = v;
        tick(1);
        en_wr = 1'b0;
    endtask

    // Count events (with ready held high) over n cycles; record their kinds as a base-4 word.
    task automatic collect(input int n, output int cnt, output int seq);
        cnt = 0; seq = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (evt_valid) begin
                seq = seq * 4 + int'(evt_kind);
                cnt++;
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not complete actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int cnt;
        int seq;
        tick(3);
        // R1: reset state
        chk(evt_valid == 1'b0, "R1 valid after reset", int'(evt_valid), 0);
        chk(en_rd == 3'b000, "R1 enables after reset", int'(en_rd), 0);
        rst_n = 1'b1;
        tick(2);

        // Sweep: global x limit x arm mask x crossing set (R2 R3 R4 R5 R7).
        for (int g = 0; g < 2; g++) begin
            for (int l = 0; l < 2; l++) begin
                for (int e = 0; e < 8; e++) begin
                    for (int c = 0; c < 8; c++) begin
                        int acc;
                        int exp_cnt;
                        int exp_seq;
                        int exp_en;
                        set_occ(0, 0, 0);
                        tick(2);
                        cfg_evt_on = g[0];
                        cfg_limit  = l[0];
                        wr_en(3'(e));
                        set_occ(c[0] ? THR : 8'd0, c[1] ? THR : 8'd0, c[2] ? THR : 8'd0);
                        acc = (g != 0) ? (e & c) : 0;
                        exp_cnt = 0; exp_seq = 0;
                        for (int i = 0; i < 3; i++) begin
                            if (acc[i]) begin
                                exp_seq = exp_seq * 4 + i;
                                exp_cnt++;
                            end
                        end
                        exp_en = (l != 0) ? (e & ~acc) : e;
                        collect(8, cnt, seq);
                        // R3 R4 R2: one event per accepted crossing, none otherwise
                        chk(cnt == exp_cnt, "R2/R3/R4 event count", cnt, exp_cnt);
                        // R7: order type, total, pool
                        chk(seq == exp_seq, "R7 event order", seq, exp_seq);
                        // R5: disarm after accept only in limit mode
                        chk(int'(en_rd) == exp_en, "R5 enable readback", int'(en_rd), exp_en);
                    end
                end
            end
        end

        // R10 latency and R8 stall hold.
        set_occ(0, 0, 0);
        cfg_evt_on = 1'b1; cfg_limit = 1'b0;
        wr_en(3'b111);
        tick(1);
        evt_ready = 1'b0;
        set_occ(THR, THR, THR);
        tick(1);
        chk(evt_valid == 1'b0, "R10 valid one edge after crossing", int'(evt_valid), 0);
        tick(1);
        chk(evt_valid == 1'b1, "R10 valid two edges after crossing", int'(evt_valid), 1);
        for (int k = 0; k < 4; k++) begin
            tick(1);
            chk(evt_valid && evt_kind == 2'd0, "R8 held kind while stalled", int'(evt_kind), 0);
        end
        evt_ready = 1'b1; tick(1); evt_ready = 1'b0;
        chk(evt_valid && evt_kind == 2'd1, "R8 R7 second kind after handshake", int'(evt_kind), 1);
        tick(2);
        chk(evt_valid && evt_kind == 2'd1, "R8 second kind held", int'(evt_kind), 1);
        evt_ready = 1'b1; tick(1);
        chk(evt_valid && evt_kind == 2'd2, "R7 third kind", int'(evt_kind), 2);
        tick(1);
        chk(evt_valid == 1'b0, "R7 queue drained", int'(evt_valid), 0);

        // R2: below, above, hold, drop, re-cross.
        set_occ(0, 0, 0);
        wr_en(3'b001);
        occ_type = THR - 8'd1;
        collect(5, cnt, seq);
        chk(cnt == 0, "R2 below threshold silent", cnt, 0);
        occ_type = THR + 8'd4;
        collect(5, cnt, seq);
        chk(cnt == 1, "R2 jump above threshold fires once", cnt, 1);
        collect(6, cnt, seq);
        chk(cnt == 0, "R2 staying above is silent", cnt, 0);
        occ_type = THR - 8'd1; tick(1);
        occ_type = THR;
        collect(5, cnt, seq);
        chk(cnt == 1, "R2 re-crossing fires again", cnt, 1);

        // R3: enable turned on while count already high stays silent.
        set_occ(0, 0, 0);
        cfg_evt_on = 1'b0; cfg_limit = 1'b1;
        wr_en(3'b111);
        set_occ(THR, THR, THR);
        collect(4, cnt, seq);
        chk(cnt == 0, "R3 gated while global off", cnt, 0);
        chk(en_rd == 3'b111, "R3 dropped crossing keeps arm bits", int'(en_rd), 7);
        cfg_evt_on = 1'b1;
        collect(6, cnt, seq);
        chk(cnt == 0, "R3 late enable does not replay", cnt, 0);

        // R6: disarmed crossings lost; re-arm restores.
        set_occ(0, 0, 0);
        cfg_limit = 1'b1;
        wr_en(3'b010);
        occ_total = THR;
        collect(5, cnt, seq);
        chk(cnt == 1 && seq == 1, "R6 first total event", seq, 1);
        chk(en_rd == 3'b000, "R6 total disarmed", int'(en_rd), 0);
        occ_total = 0; tick(1); occ_total = THR;
        collect(6, cnt, seq);
        chk(cnt == 0, "R6 crossing while disarmed lost", cnt, 0);
        wr_en(3'b010);
        collect(4, cnt, seq);
        chk(cnt == 0, "R6 re-arm does not replay lost crossing", cnt, 0);
        occ_total = 0; tick(1); occ_total = THR;
        collect(5, cnt, seq);
        chk(cnt == 1 && seq == 1, "R6 event after re-arm", cnt, 1);

        // R9: software write in the same cycle as the limit-mode clear wins.
        set_occ(0, 0, 0);
        wr_en(3'b100);
        tick(1);
        occ_pool = THR;
        en_wr = 1'b1; en_wdata = 3'b101;
        tick(1);
        en_wr = 1'b0;
        chk(en_rd == 3'b101, "R9 write beats hardware clear", int'(en_rd), 5);
        collect(4, cnt, seq);
        chk(cnt == 1 && seq == 2, "R9 pool event still issued", seq, 2);
        chk(en_rd == 3'b101, "R9 arm bits kept", int'(en_rd), 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule